// File: doc/BRIEF.md
# Pipelined Set-Bit Counter with Aligned Side-Band

This block takes a wide vector of per-site mismatch flags, one bit for each site handled by a processing array, and returns how many of those bits are set. It forms one partial count per memory line, which a later stage adds into a running score. The count comes from a binary tree of adders. Each level of the tree works on sums one bit wider than the level feeding it. An input width that is not a power of two is padded with zeros up to the next power of two.

A configuration mask chooses which adder levels end in a pipeline register. This trades latency against the length of the combinational path. Alongside the tree, a delay line carries a valid flag and a tag field. Its depth is derived from the same mask, so the tag and valid flag leave the block in the same cycle as the count they belong to.

A new vector may be presented on every cycle.

Top module: `popcount_pipe`

## Requirements
- R1: `out_count` equals the number of ones in the `in_bits` vector presented LAT cycles earlier. `out_count` is clog2(IN_W)+1 bits wide.
- R2: An all-zero vector yields a count of 0. An all-one vector yields exactly IN_W, with no wrap.
- R3: LAT is the number of set bits in REG_MASK[LEVELS-1:0], where LEVELS = clog2(IN_W). Mask bit l places a register after adder level l, and level 0 is the level nearest the inputs.
- R4: `out_valid` equals `in_valid` delayed by LAT cycles.
- R5: `out_tag` equals `in_tag` delayed by LAT cycles, so it always leaves with the count it entered with.
- R6: With REG_MASK all zero, LAT is 0 and the count, valid flag and tag follow the inputs in the same cycle.
- R7: While `rst_n` is low, and until the first valid vector has crossed the pipeline, `out_valid` stays 0.
- R8: Vectors presented on consecutive cycles produce independent counts on consecutive cycles, so throughput is one vector per cycle.
- R9: When IN_W is not a power of two, the missing inputs count as zero and the result still equals the population count of `in_bits`.
- R10: `out_count` never exceeds IN_W when `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_bits` as a vector to count |
| in_bits | input | IN_W | Per-site mismatch flags |
| in_tag | input | TAG_W | Side-band data carried with the vector |
| out_valid | output | 1 | Count on `out_count` is valid |
| out_count | output | clog2(IN_W)+1 | Number of set bits |
| out_tag | output | TAG_W | Side-band data aligned with the count |

## Verification
The bench builds several copies of the block with different register masks: none, every level, alternate levels, and a padded 12-bit width. A wrong latency count or a misplaced register would misalign the tag or valid flag from its count by one or more cycles. The all-one vector targets an adder level that is one bit too narrow, which would wrap the full-scale count to zero. The padded width targets leftover lanes that are not zeroed, which would add phantom ones. Back-to-back vectors with random bubbles catch a pipeline that stalls or merges neighbouring results.

// File: rtl/popc_pkg.sv
// Package: helpers shared by the counter tree and its checker.
// Assumes masks of at most 32 levels.
package popc_pkg;

    // Count register stages selected in the low 'levels' bits of a mask.
    function automatic int stages_in_mask(logic [31:0] mask, int levels);
        int n;
        n = 0;
        for (int i = 0; i < levels; i++) begin
            if (mask[i]) n++;
        end
        return n;
    endfunction

    // Bit offset of tree level 'lvl' inside the flat tree bus.
    function automatic int tree_offset(int pad, int lvl);
        int off;
        off = 0;
        for (int k = 0; k < lvl; k++) begin
            off += (pad >> k) * (k + 1);
        end
        return off;
    endfunction

endpackage

// File: rtl/popc_adders.sv
// One level of the counting tree: adds neighbouring pairs of IW-bit sums
// into IW+1-bit sums. Purely combinational. Assumes N_IN is even.
module popc_adders #(
    parameter int N_IN = 8,
    parameter int IW   = 1
) (
    input  logic [N_IN*IW-1:0]          din,
    output logic [(N_IN/2)*(IW+1)-1:0]  dout
);
    localparam int N_OUT = N_IN / 2;
    localparam int OW    = IW + 1;

    // Pairwise widening adders, one per output lane.
    for (genvar j = 0; j < N_OUT; j++) begin : g_pair
        assign dout[j*OW +: OW] = {1'b0, din[(2*j)*IW +: IW]}
                                + {1'b0, din[(2*j+1)*IW +: IW]};
    end
endmodule

// File: rtl/popc_delay.sv
// Fixed-depth register chain with synchronous active-low reset to zero.
// Used both for tree level registers (DEPTH=1) and the side-band line.
// Assumes DEPTH >= 1.
module popc_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    // Shift the chain by one position per cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/popcount_pipe.sv
// Pipelined population counter. A binary tree of widening adders counts the
// set bits of in_bits; REG_MASK bit l registers the output of level l.
// A delay line of matching depth carries in_valid and in_tag.
// Assumes IN_W >= 2; non-power-of-two widths are zero padded.
module popcount_pipe #(
    parameter int          IN_W     = 64,
    parameter int          TAG_W    = 8,
    parameter logic [31:0] REG_MASK = 32'h15,
    localparam int         OUT_W    = $clog2(IN_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_bits,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_count,
    output logic [TAG_W-1:0] out_tag
);
    localparam int LEVELS = $clog2(IN_W);
    localparam int PAD_W  = 1 << LEVELS;
    localparam int LAT    = popc_pkg::stages_in_mask(REG_MASK, LEVELS);
    localparam int TREE_W = popc_pkg::tree_offset(PAD_W, LEVELS + 1);

    logic [TREE_W-1:0] tree;

    // Level 0 of the tree: raw flags, padded with zeros.
    assign tree[0 +: PAD_W] = PAD_W'(in_bits);

    // One adder level per tree step, registered where the mask asks.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NI    = PAD_W >> l;
        localparam int IW    = l + 1;
        localparam int NO    = NI / 2;
        localparam int OW    = l + 2;
        localparam int OFF_I = popc_pkg::tree_offset(PAD_W, l);
        localparam int OFF_O = popc_pkg::tree_offset(PAD_W, l + 1);

        logic [NO*OW-1:0] sum_w;

        popc_adders #(.N_IN(NI), .IW(IW)) u_add (
            .din  (tree[OFF_I +: NI*IW]),
            .dout (sum_w)
        );

        if (REG_MASK[l]) begin : g_reg
            popc_delay #(.W(NO*OW), .DEPTH(1)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (sum_w),
                .dout (tree[OFF_O +: NO*OW])
            );
        end else begin : g_wire
            assign tree[OFF_O +: NO*OW] = sum_w;
        end
    end

    assign out_count = tree[popc_pkg::tree_offset(PAD_W, LEVELS) +: OUT_W];

    // Side-band line matched to the tree latency.
    if (LAT > 0) begin : g_side
        popc_delay #(.W(TAG_W + 1), .DEPTH(LAT)) u_side (
            .clk  (clk),
            .rst_n(rst_n),
            .din  ({in_valid, in_tag}),
            .dout ({out_valid, out_tag})
        );
    end else begin : g_side_wire
        assign out_valid = in_valid;
        assign out_tag   = in_tag;
    end
endmodule

// File: rtl/popc_chk.sv
// Checker for popcount_pipe: an independent reference count from
// $countones, delayed by its own history registers, is compared with the
// block's outputs. Bound to every instance of the top module.
module popc_chk #(
    parameter int          IN_W     = 64,
    parameter int          TAG_W    = 8,
    parameter logic [31:0] REG_MASK = 32'h15,
    localparam int         OUT_W    = $clog2(IN_W) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_bits,
    input logic [TAG_W-1:0] in_tag,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_count,
    input logic [TAG_W-1:0] out_tag
);
    localparam int LAT = popc_pkg::stages_in_mask(REG_MASK, $clog2(IN_W));

    logic [OUT_W-1:0] cur_cnt;
    logic [OUT_W-1:0] exp_cnt;
    logic             exp_vld;
    logic [TAG_W-1:0] exp_tag;

    // Reference count of the current input.
    always_comb cur_cnt = OUT_W'($countones(in_bits));

    if (LAT == 0) begin : g_now
        assign exp_cnt = cur_cnt;
        assign exp_vld = in_valid;
        assign exp_tag = in_tag;
    end else begin : g_hist
        logic [OUT_W-1:0] h_cnt [LAT];
        logic             h_vld [LAT];
        logic [TAG_W-1:0] h_tag [LAT];

        // History of reference values, LAT cycles deep.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < LAT; i++) begin
                    h_cnt[i] <= '0;
                    h_vld[i] <= 1'b0;
                    h_tag[i] <= '0;
                end
            end else begin
                h_cnt[0] <= cur_cnt;
                h_vld[0] <= in_valid;
                h_tag[0] <= in_tag;
                for (int i = 1; i < LAT; i++) begin
                    h_cnt[i] <= h_cnt[i-1];
                    h_vld[i] <= h_vld[i-1];
                    h_tag[i] <= h_tag[i-1];
                end
            end
        end
        assign exp_cnt = h_cnt[LAT-1];
        assign exp_vld = h_vld[LAT-1];
        assign exp_tag = h_tag[LAT-1];
    end

    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count == exp_cnt);

    // R4
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_vld);

    // R5
    tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == exp_tag);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count <= OUT_W'(IN_W));
endmodule

bind popcount_pipe popc_chk #(
    .IN_W(IN_W), .TAG_W(TAG_W), .REG_MASK(REG_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_tag(in_tag), .out_valid(out_valid), .out_count(out_count),
    .out_tag(out_tag)
);

// File: tb/popcount_pipe_tb.sv
`timescale 1ns/1ps
// Bench: five instances with different widths and register masks share one
// stimulus stream. Expected outputs come from a history of the inputs and a
// bench popcount, offset by each instance's latency from R3.
module popcount_pipe_tb;
    localparam int NCYC = 700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_bits = '0;
    logic [7:0]  in_tag = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic [63:0] h_bits [NCYC];
    logic        h_vld  [NCYC];
    logic [7:0]  h_tag  [NCYC];

    always #2.5 clk = ~clk;

    logic v0, v1, v2, v3, v4;
    logic [6:0] c0;
    logic [4:0] c1, c2, c3, c4;
    logic [7:0] t0, t1, t2, t3, t4;

    // Default: 64 bits, mask 0x15 -> three register stages (R3).
    popcount_pipe u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_bits(in_bits), .in_tag(in_tag), .out_valid(v0), .out_count(c0), .out_tag(t0));
    // 16 bits, no registers: latency 0 (R6).
    popcount_pipe #(.IN_W(16), .TAG_W(8), .REG_MASK(32'h0)) u_dut_comb (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_bits(in_bits[15:0]), .in_tag(in_tag), .out_valid(v1), .out_count(c1), .out_tag(t1));
    // 16 bits, every level registered: latency 4.
    popcount_pipe #(.IN_W(16), .TAG_W(8), .REG_MASK(32'hF)) u_dut_full (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_bits(in_bits[15:0]), .in_tag(in_tag), .out_valid(v2), .out_count(c2), .out_tag(t2));
    // 16 bits, alternate levels registered: latency 2.
    popcount_pipe #(.IN_W(16), .TAG_W(8), .REG_MASK(32'hA)) u_dut_alt (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_bits(in_bits[15:0]), .in_tag(in_tag), .out_valid(v3), .out_count(c3), .out_tag(t3));
    // 12 bits (padded to 16), mask 0x6: latency 2 (R9).
    popcount_pipe #(.IN_W(12), .TAG_W(8), .REG_MASK(32'h6)) u_dut_pad (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_bits(in_bits[11:0]), .in_tag(in_tag), .out_valid(v4), .out_count(c4), .out_tag(t4));

    function automatic int ref_pop(logic [63:0] v, int w);
        int n;
        n = 0;
        for (int i = 0; i < w; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic chk(string req, string nm, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, nm, got, exp);
        end
    endtask

    // Compare one instance against the input history at cycle k - lat.
    task automatic check_inst(string nm, string creq, int lat, int w, int k,
                              logic ov, int oc, logic [7:0] ot);
        int  s;
        logic ev;
        s  = k - lat;
        ev = (s >= 0) ? h_vld[s] : 1'b0;
        chk((k < 6) ? "R7" : "R4", {nm, " valid"}, int'(ov), int'(ev));
        if (ev) begin
            int e;
            string r;
            e = ref_pop(h_bits[s], w);
            r = creq;
            if (e == 0 || e == w) r = "R2";
            else if (s > 0 && h_vld[s-1]) r = (creq == "R1") ? "R8" : creq;
            chk(r, {nm, " count"}, oc, e);
            chk("R10", {nm, " range"}, int'(oc <= w), 1);
            chk("R5", {nm, " tag"}, int'(ot), int'(h_tag[s]));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            rst_n = (k >= 4);
            in_tag = 8'($urandom);
            case (k)
                0, 1, 2, 3: begin in_valid = 1'b0; in_bits = '1; end
                4:  begin in_valid = 1'b1; in_bits = '0; end
                5:  begin in_valid = 1'b1; in_bits = '1; end
                6:  begin in_valid = 1'b1; in_bits = 64'h1; end
                7:  begin in_valid = 1'b1; in_bits = 64'h8000_0000_0000_8800; end
                8:  begin in_valid = 1'b1; in_bits = {32{2'b01}}; end
                9:  begin in_valid = 1'b1; in_bits = {32{2'b10}}; end
                10: begin in_valid = 1'b0; in_bits = '1; end
                11: begin in_valid = 1'b1; in_bits = 64'h0000_0000_0000_F000; end
                12: begin in_valid = 1'b1; in_bits = '1; end
                default: begin
                    in_valid = ($urandom % 4) != 0;
                    in_bits = {$urandom, $urandom};
                    if ($urandom % 16 == 0) in_bits = '1;
                    if ($urandom % 16 == 0) in_bits = '0;
                end
            endcase
            h_bits[k] = in_bits;
            h_vld[k]  = in_valid && rst_n;
            h_tag[k]  = in_tag;
            #1;
            check_inst("u_dut",      "R1", 3, 64, k, v0, int'(c0), t0);
            check_inst("u_dut_comb", "R6", 0, 16, k, v1, int'(c1), t1);
            check_inst("u_dut_full", "R3", 4, 16, k, v2, int'(c2), t2);
            check_inst("u_dut_alt",  "R3", 2, 16, k, v3, int'(c3), t3);
            check_inst("u_dut_pad",  "R9", 2, 12, k, v4, int'(c4), t4);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule